// File: doc/BRIEF.md
# Serial Configuration Store Reader

This block fetches a small configuration image out of a 4-wire serial EEPROM and turns it into a checked 48-bit station address. A single `start_i` pulse starts a fetch. The block drives chip select, serial clock and serial data toward the memory, and samples the memory's data line. It reads one 16-bit word per transaction, walking from word 0 upward, until the whole byte image sits in an internal array.

Once the last word has arrived, the block XORs a parameterised run of key bytes and compares the result with a stored check byte. The block raises a one-cycle `done_o` when the result is ready. A match publishes the six address bytes with `addr_valid_o`. A mismatch raises `cksum_err_o` and holds the address invalid.

The half-period of the serial clock is a count of system clocks set by a parameter. Every change on the three control lines is held for at least that count.

Top module: `mwr_eeprom_reader`

## Requirements
- R1: While reset is asserted and right after it, `mw_cs_o`, `mw_sk_o`, `mw_di_o`, `busy_o`, `done_o`, `addr_valid_o` and `cksum_err_o` are all 0.
- R2: Every SK high phase lasts exactly HALF_CLKS system clocks. Every SK low phase while CS is high lasts HALF_CLKS clocks. No control line changes sooner than HALF_CLKS clocks after the previous change.
- R3: Each transaction starts with CS low for one half-period and then CS high. Ten bits follow on DI, each set up while SK is low and taken on the SK rising edge. The ten bits are, in order: a dummy 0, start bit 1, opcode bits 1 then 0, and the 6-bit word address MSB first. SK never rises unless CS was already high in the previous cycle.
- R4: After the address, SK stays low for one half-period with DI low. Sixteen data bits then follow, MSB first. Each bit is sampled from DO at the end of the low phase that follows an SK fall. Of word n, bits 15:8 become byte 2n and bits 7:0 become byte 2n+1.
- R5: One fetch performs NBYTES/2 transactions, with word addresses 0, 1, 2 … in ascending order. CS goes low after the last data bit of each word.
- R6: The check passes when the XOR of bytes KEY_LO through CK_IDX-1 equals byte CK_IDX (defaults 0 and 31). On a pass, `addr_valid_o`=1 and `cksum_err_o`=0. On a fail, `cksum_err_o`=1 and `addr_valid_o`=0. The two flags are never both 1.
- R7: `station_addr_o` holds bytes SA_IDX to SA_IDX+5 (default 16 to 21), with byte SA_IDX in bits 47:40 and byte SA_IDX+5 in bits 7:0.
- R8: `done_o` is high for exactly one cycle per fetch. The flags and the address take their new values in that cycle and hold them until the next completion.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored: the fetch in progress still performs exactly NBYTES/2 transactions, and only one `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins a fetch when idle |
| mw_do_i | input | 1 | Serial data from the EEPROM |
| mw_cs_o | output | 1 | EEPROM chip select |
| mw_sk_o | output | 1 | EEPROM serial clock |
| mw_di_o | output | 1 | Serial data to the EEPROM |
| busy_o | output | 1 | A fetch is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| addr_valid_o | output | 1 | Checksum passed; address is usable |
| cksum_err_o | output | 1 | Checksum mismatch on the last fetch |
| station_addr_o | output | 48 | Station address bytes |

## Verification
A new `start_i` can arrive in the very cycle that `done_o` publishes the previous result. The sequencer is already idle in that cycle, while the result stage is presenting its values. The bench raises `start_i` exactly in the sampled `done_o` cycle, using a clean image first and then a corrupted image for the second fetch. It judges three things: the first result stays intact while the second fetch runs, CS rises again within two half-periods, and the second `done_o` replaces the flags with the error outcome.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SOUT,
        ST_GAP,
        ST_SIN,
        ST_TAIL
    } mwr_state_e;
endpackage

// File: rtl/mwr_tick.sv
module mwr_tick #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(HALF_CLKS - 1));

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run_i || tick_o) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (HALF_CLKS > 1) begin : g_spacing
            // R2: two ticks are never adjacent when a half-period spans several clocks
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
    import mwr_pkg::*;
#(
    parameter int HALF_CLKS = 4,
    parameter int NWORDS    = 16,
    parameter int AW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tick_i,
    input  logic          do_i,
    output logic          busy_o,
    output logic          cs_o,
    output logic          sk_o,
    output logic          di_o,
    output logic          wr_o,
    output logic [AW-1:0] wr_word_o,
    output logic [15:0]   wr_data_o,
    output logic          fin_o
);
    localparam int OUTBITS = 4 + AW;
    localparam int CNTW    = $clog2((OUTBITS > 16) ? OUTBITS : 16);

    typedef struct packed {
        mwr_state_e         st;
        logic [CNTW-1:0]    cnt;
        logic               ph;
        logic [AW-1:0]      word;
        logic [OUTBITS-1:0] sh_out;
        logic [15:0]        sh_in;
        logic               cs;
        logic               sk;
        logic               di;
        logic               wr;
        logic               fin;
    } seq_t;

    seq_t q, n;

    always_comb begin
        n     = q;
        n.wr  = 1'b0;
        n.fin = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n.st   = ST_LEAD;
                    n.word = '0;
                end
            end
            ST_LEAD: begin
                if (tick_i) begin
                    n.st     = ST_SOUT;
                    n.cs     = 1'b1;
                    n.sk     = 1'b0;
                    n.ph     = 1'b0;
                    n.cnt    = '0;
                    n.sh_out = {4'b0110, q.word};
                    n.di     = 1'b0;
                end
            end
            ST_SOUT: begin
                if (tick_i) begin
                    if (!q.ph) begin
                        n.sk = 1'b1;
                        n.ph = 1'b1;
                    end else if (q.cnt == CNTW'(OUTBITS - 1)) begin
                        n.st = ST_GAP;
                        n.sk = 1'b0;
                        n.di = 1'b0;
                    end else begin
                        n.sk     = 1'b0;
                        n.ph     = 1'b0;
                        n.cnt    = q.cnt + 1'b1;
                        n.sh_out = q.sh_out << 1;
                        n.di     = q.sh_out[OUTBITS-2];
                    end
                end
            end
            ST_GAP: begin
                if (tick_i) begin
                    n.st  = ST_SIN;
                    n.sk  = 1'b1;
                    n.ph  = 1'b1;
                    n.cnt = '0;
                end
            end
            ST_SIN: begin
                if (tick_i) begin
                    if (q.ph) begin
                        n.sk = 1'b0;
                        n.ph = 1'b0;
                    end else begin
                        n.sh_in = {q.sh_in[14:0], do_i};
                        if (q.cnt == CNTW'(15)) begin
                            n.wr = 1'b1;
                            n.cs = 1'b0;
                            n.st = ST_TAIL;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                            n.sk  = 1'b1;
                            n.ph  = 1'b1;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick_i) begin
                    if (q.word == AW'(NWORDS - 1)) begin
                        n.st  = ST_IDLE;
                        n.fin = 1'b1;
                    end else begin
                        n.word = q.word + 1'b1;
                        n.st   = ST_LEAD;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign cs_o      = q.cs;
    assign sk_o      = q.sk;
    assign di_o      = q.di;
    assign wr_o      = q.wr;
    assign wr_word_o = q.word;
    assign wr_data_o = q.sh_in;
    assign fin_o     = q.fin;

    // Support logic for the hold-time check: cycles since the control lines last moved.
    logic [2:0]  ctl_prev_q;
    logic [15:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_prev_q <= '0;
            hold_q     <= '1;
        end else begin
            ctl_prev_q <= {q.cs, q.sk, q.di};
            if ({q.cs, q.sk, q.di} != ctl_prev_q) hold_q <= 16'd1;
            else if (hold_q != '1)                hold_q <= hold_q + 1'b1;
        end
    end

    a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_o, sk_o, di_o} != ctl_prev_q) |-> (hold_q >= 16'(HALF_CLKS)));

    a_r3_cs_before_sk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk_o) |-> $past(cs_o));
endmodule

// File: rtl/mwr_check.sv
module mwr_check #(
    parameter int NBYTES = 32,
    parameter int AW     = 6,
    parameter int KEY_LO = 0,
    parameter int CK_IDX = 31,
    parameter int SA_IDX = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] wr_word_i,
    input  logic [15:0]   wr_data_i,
    input  logic          fin_i,
    output logic          done_o,
    output logic          valid_o,
    output logic          err_o,
    output logic [47:0]   addr_o
);
    typedef struct packed {
        logic        done;
        logic        valid;
        logic        err;
        logic [47:0] addr;
    } res_t;

    res_t        q, n;
    logic [7:0]  mem_q [NBYTES];
    logic [7:0]  sum;
    logic [47:0] addr_c;

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem_q[2 * int'(wr_word_i)]     <= wr_data_i[15:8];
            mem_q[2 * int'(wr_word_i) + 1] <= wr_data_i[7:0];
        end
    end

    always_comb begin
        sum = '0;
        for (int i = KEY_LO; i < CK_IDX; i++) sum = sum ^ mem_q[i];
        for (int k = 0; k < 6; k++) addr_c[47 - 8*k -: 8] = mem_q[SA_IDX + k];
        n      = q;
        n.done = fin_i;
        if (fin_i) begin
            n.valid = (sum == mem_q[CK_IDX]);
            n.err   = (sum != mem_q[CK_IDX]);
            n.addr  = addr_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done_o  = q.done;
    assign valid_o = q.valid;
    assign err_o   = q.err;
    assign addr_o  = q.addr;

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(addr_o) && $stable(valid_o) && $stable(err_o)));
endmodule

// File: rtl/mwr_eeprom_reader.sv
module mwr_eeprom_reader #(
    parameter int HALF_CLKS = 4,
    parameter int NBYTES    = 32,
    parameter int AW        = 6,
    parameter int KEY_LO    = 0,
    parameter int CK_IDX    = 31,
    parameter int SA_IDX    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        mw_do_i,
    output logic        mw_cs_o,
    output logic        mw_sk_o,
    output logic        mw_di_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        addr_valid_o,
    output logic        cksum_err_o,
    output logic [47:0] station_addr_o
);
    localparam int NWORDS = NBYTES / 2;

    logic          tick;
    logic          wr;
    logic [AW-1:0] wr_word;
    logic [15:0]   wr_data;
    logic          fin;

    mwr_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    mwr_seq #(.HALF_CLKS(HALF_CLKS), .NWORDS(NWORDS), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (tick),
        .do_i      (mw_do_i),
        .busy_o    (busy_o),
        .cs_o      (mw_cs_o),
        .sk_o      (mw_sk_o),
        .di_o      (mw_di_o),
        .wr_o      (wr),
        .wr_word_o (wr_word),
        .wr_data_o (wr_data),
        .fin_o     (fin)
    );

    mwr_check #(.NBYTES(NBYTES), .AW(AW), .KEY_LO(KEY_LO), .CK_IDX(CK_IDX),
                .SA_IDX(SA_IDX)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .wr_word_i (wr_word),
        .wr_data_i (wr_data),
        .fin_i     (fin),
        .done_o    (done_o),
        .valid_o   (addr_valid_o),
        .err_o     (cksum_err_o),
        .addr_o    (station_addr_o)
    );

    // R5: a word is only committed when CS is being released
    a_r5_write_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !mw_cs_o);
endmodule

// File: tb/mwr_eeprom_reader_bench.sv
module mwr_eeprom_reader_bench;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mw_do = 1'b0;
    logic        mw_cs_o, mw_sk_o, mw_di_o, busy_o, done_o, addr_valid_o, cksum_err_o;
    logic [47:0] station_addr_o;

    always #4 clk = ~clk;

    mwr_eeprom_reader #(.HALF_CLKS(HALF)) u_mwr_eeprom_reader (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .mw_do_i        (mw_do),
        .mw_cs_o        (mw_cs_o),
        .mw_sk_o        (mw_sk_o),
        .mw_di_o        (mw_di_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .addr_valid_o   (addr_valid_o),
        .cksum_err_o    (cksum_err_o),
        .station_addr_o (station_addr_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;

    // {corrupt, seed}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'h00}, {1'b0, 8'h5A}, {1'b1, 8'hC3},
        {1'b0, 8'hFF}, {1'b1, 8'h17}, {1'b0, 8'h80}
    };

    // Behavioural EEPROM slave
    logic [7:0]  rom [32];
    int          edge_n = 0;
    logic [5:0]  addr_sh = '0;
    logic [15:0] dout_sh = '0;
    int          proto_err = 0;
    int          addr_bad = 0;
    int          words_seen = 0;

    always @(posedge mw_sk_o or negedge mw_cs_o) begin
        if (!mw_cs_o) begin
            edge_n = 0;
        end else begin
            edge_n++;
            if (edge_n == 1 && mw_di_o !== 1'b0) proto_err++;
            if (edge_n == 2 && mw_di_o !== 1'b1) proto_err++;
            if (edge_n == 3 && mw_di_o !== 1'b1) proto_err++;
            if (edge_n == 4 && mw_di_o !== 1'b0) proto_err++;
            if (edge_n >= 5 && edge_n <= 10) addr_sh = {addr_sh[4:0], mw_di_o};
            if (edge_n == 10) begin
                if (int'(addr_sh) != words_seen) addr_bad++;
                words_seen++;
                if (addr_sh < 6'd16) dout_sh = {rom[2*addr_sh], rom[2*addr_sh+1]};
                else                 dout_sh = 16'h0000;
            end
            if (edge_n >= 11 && edge_n <= 26) begin
                mw_do   = dout_sh[15];
                dout_sh = dout_sh << 1;
            end
        end
    end

    // SK phase measurement
    logic sk_prev = 1'b0;
    int   run = 0;
    int   hi_min = 1000000, hi_max = 0, lo_min = 1000000;
    int   done_cnt = 0;

    always @(negedge clk) begin
        if (mw_sk_o && !sk_prev) begin
            if (run > 0 && run < lo_min) lo_min = run;
            run = 1;
        end else if (!mw_sk_o && sk_prev) begin
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
            run = 1;
        end else begin
            run++;
        end
        if (!mw_cs_o) run = 0;
        sk_prev = mw_sk_o;
        if (done_o) done_cnt++;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            fails++;
            $display("FAIL R8 watchdog: actual no completion after %0d cycles, expected completion", cyc_total);
            summary();
        end
    end

    task automatic check(input logic cond, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic fill_rom(input logic [7:0] seed, input logic corrupt);
        logic [7:0] x;
        x = '0;
        for (int i = 0; i < 31; i++) begin
            rom[i] = seed ^ 8'((i * 37) + 11);
            x = x ^ rom[i];
        end
        rom[31] = corrupt ? (x ^ 8'h01) : x;
    endtask

    function automatic logic [47:0] exp_addr();
        logic [47:0] a;
        for (int k = 0; k < 6; k++) a[47 - 8*k -: 8] = rom[16 + k];
        return a;
    endfunction

    task automatic clear_meas();
        words_seen = 0; proto_err = 0; addr_bad = 0;
        hi_min = 1000000; hi_max = 0; lo_min = 1000000; done_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic judge(input logic corrupt, input logic [47:0] ea);
        check(done_o == 1'b1, "R8 done seen", 64'(done_o), 64'd1);
        check(addr_valid_o == !corrupt && cksum_err_o == corrupt, "R6 flags",
              64'({addr_valid_o, cksum_err_o}), 64'({!corrupt, corrupt}));
        if (!corrupt) check(station_addr_o == ea, "R7 R4 station address",
                            64'(station_addr_o), 64'(ea));
        check(proto_err == 0 && addr_bad == 0, "R3 framing and address order",
              64'(proto_err * 256 + addr_bad), 64'd0);
        check(words_seen == 16, "R5 transaction count", 64'(words_seen), 64'd16);
        check(hi_min == HALF && hi_max == HALF && lo_min == HALF, "R2 SK phase length",
              64'(hi_min * 65536 + hi_max * 256 + lo_min), 64'(HALF * 65536 + HALF * 256 + HALF));
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        fill_rom(8'h00, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state while held in reset
        check({mw_cs_o, mw_sk_o, mw_di_o, busy_o, done_o, addr_valid_o, cksum_err_o} == 7'b0,
              "R1 in reset", 64'({mw_cs_o, mw_sk_o, mw_di_o, busy_o, done_o, addr_valid_o, cksum_err_o}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({mw_cs_o, mw_sk_o, mw_di_o, busy_o, done_o, addr_valid_o, cksum_err_o} == 7'b0,
              "R1 after reset", 64'({mw_cs_o, mw_sk_o, mw_di_o, busy_o, done_o, addr_valid_o, cksum_err_o}), 64'd0);

        // Table of images walked by one loop
        for (int v = 0; v < 6; v++) begin
            logic [47:0] ea;
            fill_rom(VEC[v][7:0], VEC[v][8]);
            ea = exp_addr();
            clear_meas();
            pulse_start();
            wait_done();
            judge(VEC[v][8], ea);
        end

        // R9: start while busy is ignored
        begin
            logic [47:0] ea;
            fill_rom(8'h3C, 1'b0);
            ea = exp_addr();
            clear_meas();
            pulse_start();
            repeat (400) @(negedge clk);
            check(busy_o == 1'b1, "R9 busy mid fetch", 64'(busy_o), 64'd1);
            pulse_start();
            wait_done();
            judge(1'b0, ea);
            repeat (3000) @(negedge clk);
            check(busy_o == 1'b0 && done_cnt == 1 && words_seen == 16, "R9 no second fetch",
                  64'(done_cnt * 256 + words_seen), 64'(256 + 16));
            // R8: result held long after completion
            check(addr_valid_o && station_addr_o == ea, "R8 result held",
                  64'(station_addr_o), 64'(ea));
        end

        // Start raised in the same cycle as done
        begin
            logic [47:0] ea;
            int wait_cs;
            fill_rom(8'h66, 1'b0);
            ea = exp_addr();
            clear_meas();
            pulse_start();
            wait_done();
            start_i = 1'b1;
            check(addr_valid_o && station_addr_o == ea, "R8 R7 result in done cycle",
                  64'(station_addr_o), 64'(ea));
            fill_rom(8'h99, 1'b1);
            @(negedge clk);
            start_i = 1'b0;
            clear_meas();
            wait_cs = 0;
            while (!mw_cs_o && wait_cs < 50) begin
                @(negedge clk);
                wait_cs++;
            end
            check(mw_cs_o == 1'b1 && wait_cs <= 2 * HALF, "R5 restart from done cycle",
                  64'(wait_cs), 64'(HALF));
            check(addr_valid_o && !cksum_err_o && station_addr_o == ea, "R8 held during refetch",
                  64'(station_addr_o), 64'(ea));
            wait_done();
            judge(1'b1, ea);
        end

        summary();
    end
endmodule